// File: doc/BRIEF.md
# Temperature Conversion Scheduler

This block decides when a temperature sensor front end should run a conversion, and it keeps the latest result where the register file can read it. It requests one conversion as soon as reset is released. After that it requests one on its own every 64 seconds, counting the one-second tick it receives, and it also requests one whenever the user asks. The sensor answers with a done pulse and a 10-bit two's-complement code in steps of a quarter degree. The block stores that code and presents it as two read-only bytes: the integer part with its sign, and the two fraction bits.

Requests that arrive while a conversion is running are not lost. They are merged into a single follow-up conversion, which starts one cycle after the running one completes. The 64-second cadence runs on its own schedule and user activity never resets it. The two bytes come from one stored code, so a reader never sees halves taken from different conversions. A write port is present, and writes that target the two temperature addresses change nothing.

Top module: `temp_conv_sched`

## Requirements
- R1: While reset is asserted, and after it, until the first conversion completes, address 11h and address 12h both read 0. In the first clock cycle after reset is released, `senStart` is high.
- R2: Address 11h reads code bits 9:2. Address 12h reads code bits 1:0 in its bits 7:6, and its bits 5:0 always read 0. Code 0001100101b reads as 19h and 40h.
- R3: Negative codes keep their two's-complement form. Code 3FFh (-0.25 °C) reads as FFh and C0h. Code 200h (-128 °C) reads as 80h and 00h.
- R4: The block counts one-second ticks from reset. On every 64th tick an autonomous conversion is requested. When the block is idle, `senStart` is high in the cycle after that tick.
- R5: A `userConv` pulse while idle makes `senStart` high in the next cycle. `senStart` is high for one cycle per conversion.
- R6: A `userConv` pulse while a conversion is running neither starts a second conversion nor ends the running one. It is served one cycle after `senDone`.
- R7: A periodic conversion that falls due during a running conversion starts one cycle after that conversion's `senDone`. User conversions do not restart the 64-tick count.
- R8: Both bytes update at the `senDone` of every conversion, user or periodic. They update in the same cycle, from the single captured `senData`.
- R9: Writes to address 11h or 12h have no effect on the values read.
- R10: `convBusy` is high while a conversion is running or waiting to start, and low otherwise.
- R11: A `senDone` pulse while no conversion is running changes nothing.
- R12: Any number of requests during one running conversion lead to exactly one follow-up conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| secTick | input | 1 | One-cycle pulse once per second |
| userConv | input | 1 | One-cycle pulse requesting a conversion |
| convBusy | output | 1 | Conversion running or pending |
| senStart | output | 1 | One-cycle pulse that starts the sensor |
| senDone | input | 1 | One-cycle pulse from the sensor, result valid |
| senData | input | 10 | Two's-complement result, 0.25 °C per LSB |
| rdAddr | input | 8 | Register read address |
| rdData | output | 8 | Read data (0 for addresses other than 11h and 12h) |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 8 | Register write address |
| wrData | input | 8 | Register write data |

## Verification
On every cycle, the assertions check four properties:
- a start pulse always coincides with the busy flag and lasts one cycle;
- a request always leaves the block busy in the next cycle;
- busy never drops without a done pulse;
- the stored code changes only on a captured done, and then takes exactly the sensor's data.

Only the bench scenarios can show the following:
- the 64-tick cadence and the fact that user conversions do not restart it;
- the deferral of a periodic request that falls inside a running conversion;
- the merging of several requests into one follow-up;
- the byte split for positive and negative codes.

// File: rtl/temp_conv_pkg.sv
package temp_conv_pkg;

  // Strobes from the control sequencer to the result datapath
  typedef struct packed {
    logic launch;   // start a sensor conversion
    logic capture;  // running conversion finished, latch its result
  } convStrobe_t;

endpackage

// File: rtl/temp_conv_timer.sv
module temp_conv_timer #(
  parameter int PERIOD_TICKS = 64
) (
  input  logic clk,
  input  logic rstN,
  input  logic secTick,
  output logic periodDue
);

  localparam int CNT_W = (PERIOD_TICKS > 1) ? $clog2(PERIOD_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_TICKS - 1);

  logic [CNT_W-1:0] tickCnt;

  assign periodDue = secTick && (tickCnt == LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (secTick) begin
      if (tickCnt == LAST) tickCnt <= '0;
      else                 tickCnt <= tickCnt + 1'b1;
    end
  end

endmodule

// File: rtl/temp_conv_ctrl.sv
module temp_conv_ctrl
  import temp_conv_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        userConv,
  input  logic        periodDue,
  input  logic        senDone,
  output convStrobe_t stb,
  output logic        convBusy
);

  logic inFlight;   // sensor conversion running
  logic pendQ;      // conversion owed, reset value covers the power-up request
  logic launchQ;
  logic reqNow;
  logic wantStart;
  logic doneHit;

  always_comb begin
    reqNow    = userConv | periodDue;
    wantStart = !inFlight && (pendQ || reqNow);
    doneHit   = inFlight && senDone;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFlight <= 1'b0;
      pendQ    <= 1'b1;
      launchQ  <= 1'b0;
    end else begin
      launchQ <= wantStart;
      if (wantStart) begin
        inFlight <= 1'b1;
        pendQ    <= 1'b0;
      end else begin
        if (doneHit) inFlight <= 1'b0;
        pendQ <= pendQ | reqNow;
      end
    end
  end

  assign stb.launch  = launchQ;
  assign stb.capture = doneHit;
  assign convBusy    = inFlight | pendQ;

endmodule

// File: rtl/temp_conv_regs.sv
module temp_conv_regs #(
  parameter int          CODE_W  = 10,
  parameter int          DATA_W  = 8,
  parameter int          ADDR_W  = 8,
  parameter logic [7:0]  ADDR_HI = 8'h11,
  parameter logic [7:0]  ADDR_LO = 8'h12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              capture,
  input  logic [CODE_W-1:0] senData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [CODE_W-1:0] codeView
);

  localparam int FRAC_W = CODE_W - DATA_W;
  localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(ADDR_HI);
  localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(ADDR_LO);

  logic [CODE_W-1:0] codeQ;   // one register feeds both bytes
  logic [DATA_W-1:0] hiByte;
  logic [DATA_W-1:0] loByte;

  always_ff @(posedge clk) begin
    if (!rstN)        codeQ <= '0;
    else if (capture) codeQ <= senData;
  end

  always_comb begin
    hiByte = codeQ[CODE_W-1 -: DATA_W];
    loByte = {codeQ[FRAC_W-1:0], {(DATA_W-FRAC_W){1'b0}}};
    case (rdAddr)
      HI_A:    rdData = hiByte;
      LO_A:    rdData = loByte;
      default: rdData = '0;
    endcase
  end

  assign codeView = codeQ;

endmodule

// File: rtl/temp_conv_sched.sv
module temp_conv_sched
  import temp_conv_pkg::*;
#(
  parameter int         CODE_W       = 10,
  parameter int         DATA_W       = 8,
  parameter int         ADDR_W       = 8,
  parameter int         PERIOD_TICKS = 64,
  parameter logic [7:0] ADDR_HI      = 8'h11,
  parameter logic [7:0] ADDR_LO      = 8'h12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic              userConv,
  output logic              convBusy,
  output logic              senStart,
  input  logic              senDone,
  input  logic [CODE_W-1:0] senData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData
);

  convStrobe_t       ctrlStb;
  logic              periodDue;
  logic [CODE_W-1:0] codeView;
  logic              unusedWr;

  // The temperature bytes are read-only: the write port is observed and dropped
  assign unusedWr = ^{wrEn, wrAddr, wrData};

  temp_conv_timer #(.PERIOD_TICKS(PERIOD_TICKS)) u_timer (
    .clk(clk), .rstN(rstN), .secTick(secTick), .periodDue(periodDue)
  );

  temp_conv_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .userConv(userConv), .periodDue(periodDue),
    .senDone(senDone), .stb(ctrlStb), .convBusy(convBusy)
  );

  temp_conv_regs #(
    .CODE_W(CODE_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .ADDR_HI(ADDR_HI), .ADDR_LO(ADDR_LO)
  ) u_regs (
    .clk(clk), .rstN(rstN), .capture(ctrlStb.capture), .senData(senData),
    .rdAddr(rdAddr), .rdData(rdData), .codeView(codeView)
  );

  assign senStart = ctrlStb.launch;

endmodule

// File: rtl/temp_conv_sched_chk.sv
module temp_conv_sched_chk #(
  parameter int         CODE_W  = 10,
  parameter int         DATA_W  = 8,
  parameter int         ADDR_W  = 8,
  parameter logic [7:0] ADDR_LO = 8'h12
) (
  input logic              clk,
  input logic              rstN,
  input logic              userConv,
  input logic              convBusy,
  input logic              senStart,
  input logic              senDone,
  input logic              capture,
  input logic [CODE_W-1:0] senData,
  input logic [CODE_W-1:0] codeQ,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [DATA_W-1:0] rdData
);

  // R5
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    senStart |-> convBusy ##1 !senStart);

  // R6
  req_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    userConv |=> convBusy);

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (convBusy && !senDone) |=> convBusy);

  // R8
  capture_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    capture |=> (codeQ == $past(senData)));

  // R11
  code_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !capture |=> $stable(codeQ));

  // R2
  frac_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr == ADDR_W'(ADDR_LO)) |-> (rdData[DATA_W-CODE_W+DATA_W-1:0] == '0));

endmodule

bind temp_conv_sched temp_conv_sched_chk #(
  .CODE_W(CODE_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ADDR_LO(ADDR_LO)
) u_chk (
  .clk(clk), .rstN(rstN), .userConv(userConv), .convBusy(convBusy),
  .senStart(senStart), .senDone(senDone), .capture(ctrlStb.capture),
  .senData(senData), .codeQ(codeView), .rdAddr(rdAddr), .rdData(rdData)
);

// File: tb/temp_conv_sched_bench.sv
module temp_conv_sched_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       secTick = 1'b0;
  logic       userConv = 1'b0;
  logic       convBusy;
  logic       senStart;
  logic       senDone = 1'b0;
  logic [9:0] senData = '0;
  logic [7:0] rdAddr = '0;
  logic [7:0] rdData;
  logic       wrEn = 1'b0;
  logic [7:0] wrAddr = '0;
  logic [7:0] wrData = '0;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  temp_conv_sched u_temp_conv_sched (
    .clk(clk), .rstN(rstN), .secTick(secTick), .userConv(userConv),
    .convBusy(convBusy), .senStart(senStart), .senDone(senDone),
    .senData(senData), .rdAddr(rdAddr), .rdData(rdData),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData)
  );

  // {code, byte at 11h, byte at 12h}
  localparam logic [25:0] VECS [6] = '{
    {10'h065, 8'h19, 8'h40},   // +25.25
    {10'h3FF, 8'hFF, 8'hC0},   // -0.25
    {10'h1FF, 8'h7F, 8'hC0},   // +127.75
    {10'h200, 8'h80, 8'h00},   // -128.0
    {10'h001, 8'h00, 8'h40},   // +0.25
    {10'h2A6, 8'hA9, 8'h80}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    rdAddr = a;
    #0.5;
    d = rdData;
  endtask

  task automatic chkRegs(input string req, input logic [7:0] hi, input logic [7:0] lo);
    logic [7:0] d;
    rd(8'h11, d); chk({req, " hi"}, 32'(d), 32'(hi));
    rd(8'h12, d); chk({req, " lo"}, 32'(d), 32'(lo));
  endtask

  task automatic finishConv(input logic [9:0] code);
    senDone = 1'b1; senData = code;
    cyc();
    senDone = 1'b0;
  endtask

  task automatic userStart(input string req);
    userConv = 1'b1;
    cyc();
    userConv = 1'b0;
    chk({req, " senStart"}, 32'(senStart), 32'd1);
  endtask

  task automatic secPulse();
    secTick = 1'b1;
    cyc();
    secTick = 1'b0;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    int launches;
    // R1 reset values
    repeat (3) cyc();
    chkRegs("R1 in reset", 8'h00, 8'h00);
    rstN = 1'b1;
    cyc();
    chk("R1 power-up start", 32'(senStart), 32'd1);
    chk("R10 busy at start", 32'(convBusy), 32'd1);
    chkRegs("R1 before first done", 8'h00, 8'h00);
    cyc();
    chk("R5 single pulse", 32'(senStart), 32'd0);
    finishConv(10'h065);
    chkRegs("R8 power-up result", 8'h19, 8'h40);
    chk("R10 idle after done", 32'(convBusy), 32'd0);

    // R2 / R3 vector walk via user conversions
    foreach (VECS[i]) begin
      userStart("R5 vec");
      finishConv(VECS[i][25:16]);
      chkRegs(VECS[i][25] ? "R3 negative" : "R2 positive", VECS[i][15:8], VECS[i][7:0]);
    end

    // R6 request while busy held, not aborting
    userStart("R6 first");
    userConv = 1'b1; cyc(); userConv = 1'b0;
    chk("R6 no restart", 32'(senStart), 32'd0);
    repeat (3) begin
      cyc();
      chk("R6 busy kept", 32'(convBusy), 32'd1);
      chk("R6 no second start", 32'(senStart), 32'd0);
    end
    finishConv(10'h0F0);
    chkRegs("R8 user result", 8'h3C, 8'h00);
    chk("R6 not yet", 32'(senStart), 32'd0);
    cyc();
    chk("R6 served after done", 32'(senStart), 32'd1);
    finishConv(10'h0F1);
    chk("R10 idle", 32'(convBusy), 32'd0);

    // R12 several requests merged
    userStart("R12 first");
    repeat (2) begin userConv = 1'b1; cyc(); userConv = 1'b0; cyc(); end
    finishConv(10'h010);
    launches = 0;
    repeat (2) begin cyc(); launches += senStart; end
    finishConv(10'h011);
    repeat (5) begin cyc(); launches += senStart; end
    chk("R12 one follow-up", 32'(launches), 32'd1);
    chk("R12 idle after", 32'(convBusy), 32'd0);

    // R4 periodic cadence: 63 ticks quiet, 64th launches
    launches = 0;
    repeat (63) begin secPulse(); launches += senStart; end
    chk("R4 quiet before 64", 32'(launches), 32'd0);
    secPulse();
    chk("R4 start on 64th tick", 32'(senStart), 32'd1);
    finishConv(10'h3F6);
    chkRegs("R8 periodic result", 8'hFD, 8'h80);

    // R7 user conversion does not restart the count
    launches = 0;
    repeat (30) begin secPulse(); launches += senStart; end
    userStart("R7 user mid-period");
    finishConv(10'h004);
    repeat (33) begin secPulse(); launches += senStart; end
    chk("R7 quiet until 128th tick", 32'(launches), 32'd0);
    userStart("R7 user busy");
    secPulse();
    chk("R7 due held while busy", 32'(senStart), 32'd0);
    finishConv(10'h008);
    chk("R7 not on done edge", 32'(senStart), 32'd0);
    cyc();
    chk("R7 deferred periodic start", 32'(senStart), 32'd1);
    finishConv(10'h0C9);
    chkRegs("R8 deferred result", 8'h32, 8'h40);

    // R9 writes ignored
    wrEn = 1'b1; wrAddr = 8'h11; wrData = 8'h55; cyc();
    wrAddr = 8'h12; wrData = 8'hAA; cyc();
    wrEn = 1'b0;
    chkRegs("R9 writes ignored", 8'h32, 8'h40);

    // R11 stray done while idle
    finishConv(10'h155);
    chkRegs("R11 stray done", 8'h32, 8'h40);
    chk("R11 no start", 32'(senStart), 32'd0);
    chk("R11 still idle", 32'(convBusy), 32'd0);

    summary();
    $finish;
  end

endmodule